// File: doc/BRIEF.md
# Nine-bit asynchronous serial transmitter

The block sends characters on a single serial line in asynchronous format. A character is written into a one-entry transmit buffer through a register-bus style write strobe. When the line is free and the bit-rate enable pulses, the buffer moves into a shift register, and the frame goes out one bit per enable period. The frame is a low start bit, the data bits least significant first, an optional ninth bit, and a high stop bit.

The ninth bit lives in its own register, written through a separate strobe. It holds its value across characters, so a stream of characters that share the same ninth bit needs only one write to it. Its value is captured into the shifter at the moment the buffer hands over its character. Software that sets it before writing the data therefore gets that value on that same character. A later write never reaches a character that is already shifting. Two status outputs report that the buffer can accept a character and that the whole transmitter has gone quiet.

Top module: `uart9_tx`

## Requirements
- R1: While reset is applied and in the first cycle after it, `txd_o` is 1, `buf_empty_o` is 1 and `tx_done_o` is 1.
- R2: With `mode9_i` = 0 when a character is loaded, the frame is 10 bits: one 0 start bit, then `data_i` bit 0 up to bit 7, then one 1 stop bit.
- R3: With `mode9_i` = 1 when a character is loaded, the frame is 11 bits: the start bit, data bits 0 to 7, then the ninth-bit value, then the stop bit.
- R4: A character is loaded only on a cycle with `bit_en_i` = 1. Each bit of the frame stays on `txd_o` for exactly the number of clock cycles between two `bit_en_i` pulses.
- R5: The ninth-bit register keeps its value until `ninth_we_i` is pulsed. A character sent in 9-bit mode without a new write to it carries the most recently written value.
- R6: A ninth-bit write made before the data write of a character applies to that character.
- R7: A ninth-bit write while a character is shifting does not change the ninth bit of that character.
- R8: `buf_empty_o` goes to 0 in the cycle after a `data_we_i` write. It returns to 1 in the cycle after the buffer contents move into the shifter.
- R9: `tx_done_o` is 1 only when the shifter is idle and the buffer is empty. It is 0 during every frame. While it is 1, `txd_o` is 1.
- R10: If the buffer is full when a stop bit ends, the next start bit follows in the very next cycle, with no idle bit in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_en_i | input | 1 | One-cycle pulse per bit period |
| mode9_i | input | 1 | 1 selects 9-bit characters; sampled at load |
| data_we_i | input | 1 | Write strobe for the transmit buffer |
| data_i | input | DATA_W | Character written to the buffer |
| ninth_we_i | input | 1 | Write strobe for the ninth-bit register |
| ninth_i | input | 1 | Value written to the ninth-bit register |
| txd_o | output | 1 | Serial output, high when idle |
| buf_empty_o | output | 1 | Buffer can accept a character |
| tx_done_o | output | 1 | Shifter idle and buffer empty |

## Verification
The hardest case to reach is a ninth-bit write that lands while one character is on the line and the next is about to be written. It must affect only the next character. The stimulus table gets there by waiting for the buffer-empty rise, which marks a load. It then writes the ninth bit and the next data at once, so every 9-bit entry both overlaps a shifting frame and feeds a back-to-back frame. An independent line monitor checks every clock cycle of each frame against the expected bit. This also covers exact bit length and the absence of a gap between frames.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  localparam int unsigned DATA_W_DEF = 8;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } tx_state_e;
endpackage

// File: rtl/uart9_txbuf.sv
module uart9_txbuf #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          data_we_i,
  input  logic [DW-1:0] data_i,
  input  logic          ninth_we_i,
  input  logic          ninth_i,
  input  logic          take_i,
  output logic [DW-1:0] data_o,
  output logic          ninth_o,
  output logic          full_o
);
  logic [DW-1:0] data_q;
  logic          t8_q;
  logic          full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (data_we_i) data_q <= data_i;
      // a write in the take cycle refills the buffer
      if (data_we_i)   full_q <= 1'b1;
      else if (take_i) full_q <= 1'b0;
    end
  end

  // sticky ninth bit, untouched by loads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         t8_q <= 1'b0;
    else if (ninth_we_i) t8_q <= ninth_i;
  end

  assign data_o  = data_q;
  assign ninth_o = t8_q;
  assign full_o  = full_q;

  AST_T8_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ninth_we_i |=> $stable(t8_q)); // R5
  AST_WRITE_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i |=> full_q); // R8
endmodule

// File: rtl/uart9_txshift.sv
module uart9_txshift
  import uart9_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_en_i,
  input  logic          mode9_i,
  input  logic          full_i,
  input  logic [DW-1:0] data_i,
  input  logic          ninth_i,
  output logic          take_o,
  output logic          busy_o,
  output logic          txd_o
);
  localparam int unsigned SH_W  = DW + 3;
  localparam int unsigned CNT_W = $clog2(SH_W + 1);
  localparam logic [CNT_W-1:0] LEN9 = CNT_W'(DW + 3);
  localparam logic [CNT_W-1:0] LEN8 = CNT_W'(DW + 2);

  tx_state_e        state_q;
  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] nbits_q;
  logic             last_bit;
  logic             busy;

  assign busy     = (state_q == ST_SHIFT);
  assign last_bit = (cnt_q == nbits_q - CNT_W'(1));
  // load when idle, or exactly at the end of a stop bit
  assign take_o   = bit_en_i && full_i && (!busy || last_bit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '1;
      cnt_q   <= '0;
      nbits_q <= LEN8;
    end else if (take_o) begin
      state_q <= ST_SHIFT;
      sh_q    <= {1'b1, (mode9_i ? ninth_i : 1'b1), data_i, 1'b0};
      cnt_q   <= '0;
      nbits_q <= mode9_i ? LEN9 : LEN8;
    end else if (bit_en_i && busy) begin
      if (last_bit) begin
        state_q <= ST_IDLE;
      end else begin
        sh_q  <= {1'b1, sh_q[SH_W-1:1]};
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign busy_o = busy;
  assign txd_o  = busy ? sh_q[0] : 1'b1;

  AST_BIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !bit_en_i) |=> ($stable(sh_q) && $stable(cnt_q))); // R4
  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> (txd_o == 1'b0)); // R2
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (cnt_q < nbits_q)); // R3
  AST_LOAD_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !bit_en_i) |=> !busy); // R4
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx #(
  parameter int unsigned DATA_W = uart9_pkg::DATA_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              mode9_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ninth_we_i,
  input  logic              ninth_i,
  output logic              txd_o,
  output logic              buf_empty_o,
  output logic              tx_done_o
);
  logic [DATA_W-1:0] buf_data;
  logic              buf_ninth;
  logic              buf_full;
  logic              take;
  logic              busy;

  uart9_txbuf #(.DW(DATA_W)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_we_i  (data_we_i),
    .data_i     (data_i),
    .ninth_we_i (ninth_we_i),
    .ninth_i    (ninth_i),
    .take_i     (take),
    .data_o     (buf_data),
    .ninth_o    (buf_ninth),
    .full_o     (buf_full)
  );

  uart9_txshift #(.DW(DATA_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .mode9_i  (mode9_i),
    .full_i   (buf_full),
    .data_i   (buf_data),
    .ninth_i  (buf_ninth),
    .take_o   (take),
    .busy_o   (busy),
    .txd_o    (txd_o)
  );

  assign buf_empty_o = !buf_full;
  assign tx_done_o   = !busy && !buf_full;

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> txd_o); // R9
  AST_TAKE_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !data_we_i) |=> buf_empty_o); // R8
endmodule

// File: tb/uart9_tx_tb_top.sv
module uart9_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_P      = 8;
  localparam int NVEC       = 8;

  // {mode9, write_t8, t8, data}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 8'hA5},
    {1'b0, 1'b0, 1'b0, 8'h01},
    {1'b1, 1'b1, 1'b1, 8'h3C},  // R6
    {1'b1, 1'b0, 1'b0, 8'hC3},  // R5 reuse 1
    {1'b1, 1'b1, 1'b0, 8'hFF},  // R7 write during previous frame
    {1'b1, 1'b0, 1'b0, 8'h00},  // R5 reuse 0
    {1'b0, 1'b1, 1'b1, 8'h80},  // R2 ninth unused
    {1'b1, 1'b0, 1'b0, 8'h5A}   // R5 reuse 1
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_en_i = 1'b0;
  logic       mode9_i = 1'b0;
  logic       data_we_i = 1'b0;
  logic [7:0] data_i = '0;
  logic       ninth_we_i = 1'b0;
  logic       ninth_i = 1'b0;
  logic       txd_o, buf_empty_o, tx_done_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  ended = 1'b0;
  logic t8_model = 1'b0;
  logic [11:0] exp_bits[$];
  int          exp_len[$];

  uart9_tx dut_i (
    .clk_i, .rst_ni, .bit_en_i, .mode9_i, .data_we_i, .data_i,
    .ninth_we_i, .ninth_i, .txd_o, .buf_empty_o, .tx_done_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  initial begin : tick_gen
    int c;
    c = 0;
    forever begin
      @(negedge clk_i);
      bit_en_i = (c == BIT_P - 1);
      c = (c == BIT_P - 1) ? 0 : c + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic write_t8(input logic v);
    @(negedge clk_i);
    ninth_we_i = 1'b1; ninth_i = v; t8_model = v;
    @(negedge clk_i);
    ninth_we_i = 1'b0;
  endtask

  task automatic write_data(input logic [7:0] d);
    @(negedge clk_i);
    data_we_i = 1'b1; data_i = d;
    if (mode9_i) begin
      exp_bits.push_back({1'b1, t8_model, d, 1'b0});
      exp_len.push_back(11);
    end else begin
      exp_bits.push_back({2'b01, d, 1'b0});
      exp_len.push_back(10);
    end
    @(negedge clk_i);
    data_we_i = 1'b0;
    check(buf_empty_o == 1'b0, "R8 empty after write", buf_empty_o, 0);
  endtask

  task automatic wait_empty();
    for (int i = 0; i < 400 && !buf_empty_o; i++) @(negedge clk_i);
    check(buf_empty_o == 1'b1, "R8 buffer refill", buf_empty_o, 1);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 600 && !tx_done_o; i++) @(negedge clk_i);
    check(tx_done_o == 1'b1, "R9 done reached", tx_done_o, 1);
  endtask

  // line monitor: every cycle of every frame against the expected bit
  initial begin : monitor
    bit skip;
    skip = 1'b0;
    wait (rst_ni);
    forever begin
      if (!skip) @(negedge clk_i);
      skip = 1'b0;
      if (!txd_o) begin
        if (exp_len.size() == 0) begin
          check(1'b0, "R2 unexpected start", 0, 1);
        end else begin
          logic [11:0] f;
          int len;
          bit ok, tc_ok;
          f = exp_bits.pop_front();
          len = exp_len.pop_front();
          ok = 1'b1; tc_ok = 1'b1;
          for (int i = 0; i < len * BIT_P; i++) begin
            if (i > 0) @(negedge clk_i);
            if (txd_o !== f[i / BIT_P]) ok = 1'b0;
            if (tx_done_o) tc_ok = 1'b0;
          end
          check(ok, (len == 11) ? "R3 R4 nine-bit frame" : "R2 R4 eight-bit frame",
                0, f);
          check(tc_ok, "R9 done low in frame", tc_ok, 1);
          @(negedge clk_i);
          if (exp_len.size() > 0)
            check(txd_o == 1'b0, "R10 back-to-back start", txd_o, 0);
          else
            check(txd_o == 1'b1, "R9 idle after frame", txd_o, 1);
          skip = 1'b1;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin : main
    repeat (3) @(negedge clk_i);
    check(txd_o == 1'b1 && buf_empty_o && tx_done_o, "R1 in reset",
          {txd_o, buf_empty_o, tx_done_o}, 3'b111);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(txd_o == 1'b1 && buf_empty_o && tx_done_o, "R1 after reset",
          {txd_o, buf_empty_o, tx_done_o}, 3'b111);

    // R4: load waits for a tick
    write_data(8'h96);
    check(txd_o == 1'b1 || bit_en_i, "R4 no load before tick", txd_o, 1);
    check(tx_done_o == 1'b0, "R9 done low when full", tx_done_o, 0);
    wait_done();

    for (int v = 0; v < NVEC; v++) begin
      wait_empty();
      mode9_i = VEC[v][10];
      if (VEC[v][9]) write_t8(VEC[v][8]);
      write_data(VEC[v][7:0]);
    end
    wait_done();
    repeat (2) @(negedge clk_i);
    check(exp_len.size() == 0, "R2 all frames seen", exp_len.size(), 0);
    check(txd_o == 1'b1, "R9 line idle", txd_o, 1);

    // R7 directed: flip ninth bit right after load
    mode9_i = 1'b1;
    write_t8(1'b1);
    write_data(8'h0F);
    wait_empty();
    write_t8(1'b0);
    wait_done();
    repeat (2) @(negedge clk_i);
    check(exp_len.size() == 0, "R7 frame consumed", exp_len.size(), 0);

    // R5 directed: next char reuses the value written during shifting
    write_data(8'hF0);
    wait_done();
    repeat (2) @(negedge clk_i);
    check(exp_len.size() == 0, "R5 frame consumed", exp_len.size(), 0);
    finish_run();
  end
endmodule